// File: doc/BRIEF.md
# SPI flash command controller

This block runs one short command against a serial NOR flash and keeps the reply. Software places up to four command bytes in an opcode register. It then writes a control word that holds a transmit byte count, a receive byte count and a start bit. While the transaction runs, software polls a busy flag. When the flag clears, it reads up to four reply bytes from a data register.

The serial side uses SPI mode 0. The clock idles low, the controller samples MISO on the rising edge, and it changes MOSI only while the clock is low. The serial clock is the system clock divided by the parameter `SCLK_DIV`. The host side is a plain 32-bit register slave with a combinational read port and single-cycle writes.

A typical use is reading a flash electronic signature to learn the part size. Software writes opcode 0xAB and sends four command bytes, of which three are dummy bytes. It then receives one byte, which is the signature.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, busy reads 0, and the control, opcode and data registers all read 0.
- R2: The registers sit at these byte offsets: control at 0x00, opcode at 0x04, data at 0x08. In the control register, bits 3:0 hold the transmit byte count, bits 7:4 hold the receive byte count, bit 8 is start (it always reads 0), and bit 16 is busy. The opcode register can be read and written. The data register is read-only.
- R3: A control write with start set and at least one non-zero count sets busy from the next cycle on. Busy stays set until chip select is released. A start with both counts zero launches nothing.
- R4: MOSI carries the opcode register bytes in the order bits 7:0, 15:8, 23:16, 31:24, each byte MSB first. Transmit bytes beyond the fourth are 0x00, and MOSI is 0 during the receive bytes.
- R5: The data register is cleared when a transaction starts. Received bytes are packed with the first byte in bits 7:0, the second in bits 15:8, and so on. Only the first four received bytes are kept, and lanes that receive nothing read 0.
- R6: SCLK is low whenever chip select is high. Its period is `SCLK_DIV` system clocks. MOSI is stable while SCLK is high, and MISO is sampled on the SCLK rising edge.
- R7: Chip select stays low for the whole transaction. The first SCLK rising edge comes `SCLK_DIV/2` cycles after chip select falls. Chip select rises `SCLK_DIV` cycles after the last SCLK falling edge.
- R8: While busy is set, every register write is ignored, including a second start.
- R9: A command of opcode 0xAB with transmit count 4 and receive count 1 returns the flash signature byte in data bits 7:0. Signatures 0x13, 0x14, 0x15 and 0x16 stand for parts of 1, 2, 4 and 8 MiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running transaction, because it must be ignored. The stimulus starts a command with several bytes, then writes a new opcode and a second start while chip select is still low. Afterwards it reads back both registers and counts chip-select falls to show that only one transaction ran. The count boundaries are reached by sweeping every transmit/receive pair from 0 to 5. That sweep covers transmit counts past the four opcode bytes and receive counts past the four data lanes. For each pair, a behavioural flash model logs every MOSI byte and returns a byte pattern that the bench can predict from the byte position.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned CNT_W      = 4;
    localparam int unsigned LANES      = REG_W / 8;

    localparam int unsigned OFF_CTRL   = 0;
    localparam int unsigned OFF_OPCODE = 4;
    localparam int unsigned OFF_DATA   = 8;

    localparam int unsigned TXC_LSB    = 0;
    localparam int unsigned RXC_LSB    = 4;
    localparam int unsigned START_BIT  = 8;
    localparam int unsigned BUSY_BIT   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HI,
        ST_LO,
        ST_TAIL
    } eng_state_e;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic [REG_W-1:0]  rx_data,
    output logic              launch,
    output logic [CNT_W-1:0]  launch_tx,
    output logic [CNT_W-1:0]  launch_rx,
    output logic [REG_W-1:0]  opcode
);

    typedef struct packed {
        logic [REG_W-1:0] opcode;
        logic [CNT_W-1:0] txc;
        logic [CNT_W-1:0] rxc;
    } regs_t;

    regs_t q, d;

    logic wr_ok;
    logic hit_ctrl;
    logic hit_opcode;
    logic hit_data;
    logic [CNT_W-1:0] w_tx;
    logic [CNT_W-1:0] w_rx;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[REG_W-1:START_BIT+1]};

    always_comb begin
        hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
        hit_opcode = (bus_addr == ADDR_W'(OFF_OPCODE));
        hit_data   = (bus_addr == ADDR_W'(OFF_DATA));
        wr_ok      = bus_en && bus_we && !busy;
        w_tx       = bus_wdata[TXC_LSB +: CNT_W];
        w_rx       = bus_wdata[RXC_LSB +: CNT_W];

        d = q;
        if (wr_ok && hit_opcode) begin
            d.opcode = bus_wdata;
        end
        if (wr_ok && hit_ctrl) begin
            d.txc = w_tx;
            d.rxc = w_rx;
        end

        launch    = wr_ok && hit_ctrl && bus_wdata[START_BIT]
                    && ((w_tx != '0) || (w_rx != '0));
        launch_tx = w_tx;
        launch_rx = w_rx;
        opcode    = q.opcode;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[TXC_LSB +: CNT_W] = q.txc;
            bus_rdata[RXC_LSB +: CNT_W] = q.rxc;
            bus_rdata[BUSY_BIT]         = busy;
        end else if (hit_opcode) begin
            bus_rdata = q.opcode;
        end else if (hit_data) begin
            bus_rdata = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int unsigned TW = (HALF > 1) ? $clog2(HALF) : 1;

    generate
        if (HALF <= 1) begin : g_every
            assign tick = en;
        end else begin : g_count
            logic [TW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = en && (cnt_q == TW'(HALF - 1));
                cnt_d = cnt_q;
                if (!en || tick) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             launch,
    input  logic [CNT_W-1:0] launch_tx,
    input  logic [CNT_W-1:0] launch_rx,
    input  logic [REG_W-1:0] opcode,
    input  logic             miso,
    output logic             busy,
    output logic [REG_W-1:0] rx_data,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi
);

    localparam int unsigned BIT_W  = CNT_W + 4;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef struct packed {
        eng_state_e       st;
        logic [REG_W-1:0] sh;
        logic [BIT_W-1:0] bit_cnt;
        logic [BIT_W-1:0] tot;
        logic [BIT_W-1:0] txb;
        logic [REG_W-1:0] data;
        logic             sclk;
        logic             cs_n;
        logic             mosi;
    } eng_t;

    eng_t q, d;

    logic [REG_W-1:0] sh_load;
    logic [REG_W-1:0] sh_next;
    logic [REG_W-1:0] data_smp;
    logic [BIT_W-1:0] rx_idx;
    logic [BIT_W-4:0] rx_lane;
    logic [BIT_W-1:0] bit_inc;
    logic [BIT_W-1:0] ld_tot;
    logic [BIT_W-1:0] ld_txb;

    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            sh_load[REG_W-1-8*i -: 8] = opcode[8*i +: 8];
        end
        ld_txb = BIT_W'(launch_tx) << 3;
        ld_tot = (BIT_W'(launch_tx) + BIT_W'(launch_rx)) << 3;
    end

    always_comb begin
        rx_idx   = q.bit_cnt - q.txb;
        rx_lane  = rx_idx[BIT_W-1:3];
        data_smp = q.data;
        if ((q.bit_cnt >= q.txb) && (rx_lane < (BIT_W-3)'(LANES))) begin
            data_smp[{rx_lane[LANE_W-1:0], ~rx_idx[2:0]}] = miso;
        end
        sh_next = q.sh << 1;
        bit_inc = q.bit_cnt + 1'b1;
    end

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (launch) begin
                    d.st      = ST_LEAD;
                    d.sh      = sh_load;
                    d.bit_cnt = '0;
                    d.tot     = ld_tot;
                    d.txb     = ld_txb;
                    d.data    = '0;
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b0;
                    d.mosi    = (launch_tx != '0) ? sh_load[REG_W-1] : 1'b0;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.st   = ST_HI;
                    d.sclk = 1'b1;
                    d.data = data_smp;
                end
            end
            ST_HI: begin
                if (tick) begin
                    d.st      = ST_LO;
                    d.sclk    = 1'b0;
                    d.bit_cnt = bit_inc;
                    d.sh      = sh_next;
                    d.mosi    = (bit_inc < q.txb) ? sh_next[REG_W-1] : 1'b0;
                end
            end
            ST_LO: begin
                if (tick) begin
                    if (q.bit_cnt == q.tot) begin
                        d.st = ST_TAIL;
                    end else begin
                        d.st   = ST_HI;
                        d.sclk = 1'b1;
                        d.data = data_smp;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.st   = ST_IDLE;
                    d.cs_n = 1'b1;
                    d.mosi = 1'b0;
                end
            end
            default: begin
                d.st   = ST_IDLE;
                d.cs_n = 1'b1;
                d.sclk = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign rx_data = q.data;
    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign mosi    = q.mosi;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int unsigned HALF = (SCLK_DIV < 2) ? 1 : SCLK_DIV / 2;

    logic             eng_busy;
    logic             eng_tick;
    logic             reg_launch;
    logic [CNT_W-1:0] reg_ltx;
    logic [CNT_W-1:0] reg_lrx;
    logic [REG_W-1:0] reg_opcode;
    logic [REG_W-1:0] eng_data;

    spi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (eng_busy),
        .rx_data   (eng_data),
        .launch    (reg_launch),
        .launch_tx (reg_ltx),
        .launch_rx (reg_lrx),
        .opcode    (reg_opcode)
    );

    spi_cmd_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_busy),
        .tick  (eng_tick)
    );

    spi_cmd_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (eng_tick),
        .launch    (reg_launch),
        .launch_tx (reg_ltx),
        .launch_rx (reg_lrx),
        .opcode    (reg_opcode),
        .miso      (spi_miso),
        .busy      (eng_busy),
        .rx_data   (eng_data),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi)
    );

endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic [31:0]       opcode,
    input logic              sclk,
    input logic              cs_n,
    input logic              mosi
);

    assert_sclk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_mosi_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    assert_busy_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_en && bus_we && (bus_addr == '0) && bus_wdata[8]));

    assert_cs_falls_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $fell(cs_n));

    assert_cs_rises_with_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $rose(cs_n));

    assert_opcode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(opcode));

endmodule

bind spi_cmd_ctrl spi_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (eng_busy),
    .opcode    (reg_opcode),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi)
);

// File: tb/sim_spi_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_spi_cmd_ctrl;

    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_cmd_ctrl #(.ADDR_W(4), .SCLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural flash model
    logic [7:0] sig = 8'h13;
    logic [7:0] mlog [0:31];
    logic [7:0] m_sh = '0;
    int         m_bits = 0;
    int         cs_falls = 0;

    function automatic logic [7:0] pat(input int k);
        return 8'(8'hC3 ^ (k * 29));
    endfunction

    function automatic logic [7:0] resp(input int k, input logic [7:0] first);
        if (first == 8'hAB && k >= 4) return sig;
        return pat(k);
    endfunction

    function automatic logic bit_of(input int n);
        logic [7:0] b;
        b = resp(n / 8, mlog[0]);
        return b[7 - (n % 8)];
    endfunction

    always @(negedge spi_cs_n) begin
        m_bits = 0;
        cs_falls++;
        spi_miso = bit_of(0);
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            m_sh = {m_sh[6:0], spi_mosi};
            m_bits = m_bits + 1;
            if (m_bits % 8 == 0) mlog[m_bits/8 - 1] = m_sh;
        end
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) spi_miso = bit_of(m_bits);
    end

    // serial timing monitor
    int  cyc = 0;
    int  t_rise = 0, t_fall = 0, t_csf = 0;
    bit  seen_rise = 0;
    logic p_sclk = 0, p_cs = 1, p_mosi = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (p_cs && !spi_cs_n) begin
                t_csf = cyc;
                seen_rise = 0;
            end
            if (!p_sclk && spi_sclk) begin
                if (!seen_rise) check("R7 first edge delay", 32'(cyc - t_csf), 32'(HALF));
                else            check("R6 sclk period", 32'(cyc - t_rise), 32'(DIV));
                seen_rise = 1;
                t_rise = cyc;
            end
            if (p_sclk && !spi_sclk) t_fall = cyc;
            if (!p_cs && spi_cs_n) check("R7 cs release delay", 32'(cyc - t_fall), 32'(DIV));
            if (p_sclk && spi_sclk && (p_mosi !== spi_mosi))
                check("R6 mosi moved while sclk high", 32'(spi_mosi), 32'(p_mosi));
            if (spi_cs_n && spi_sclk) check("R6 sclk idle low", 32'(spi_sclk), 32'd0);
        end
        p_sclk = spi_sclk;
        p_cs = spi_cs_n;
        p_mosi = spi_mosi;
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(4'h0, v);
            if (!v[16]) return;
        end
        check("R3 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic run_cmd(input int tx, input int rx, input logic [31:0] op);
        logic [31:0] v, exp;
        logic [7:0]  eb;
        bus_write(4'h4, op);
        bus_write(4'h0, 32'h100 | 32'(rx << 4) | 32'(tx));
        bus_read(4'h0, v);
        check($sformatf("R3 busy after start tx=%0d rx=%0d", tx, rx), 32'(v[16]), 32'd1);
        wait_idle();
        bus_read(4'h8, v);
        exp = '0;
        for (int j = 0; j < 4; j++)
            if (j < rx) exp[8*j +: 8] = resp(tx + j, op[7:0]);
        check($sformatf("R5 data tx=%0d rx=%0d", tx, rx), v, exp);
        for (int k = 0; k < tx + rx; k++) begin
            eb = (k < tx && k < 4) ? op[8*k +: 8] : 8'h00;
            check($sformatf("R4 mosi byte %0d tx=%0d rx=%0d", k, tx, rx), 32'(mlog[k]), 32'(eb));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int falls0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sclk", 32'(spi_sclk), 32'd0);
        check("R1 mosi", 32'(spi_mosi), 32'd0);
        bus_read(4'h0, v); check("R1 ctrl", v, 32'h0);
        bus_read(4'h4, v); check("R1 opcode", v, 32'h0);
        bus_read(4'h8, v); check("R1 data", v, 32'h0);

        // R2 register map, start reads 0, data read-only
        bus_write(4'h4, 32'hA5C3_0F11);
        bus_read(4'h4, v); check("R2 opcode readback", v, 32'hA5C3_0F11);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, v); check("R2 data read-only", v, 32'h0);

        // R3 zero counts launch nothing
        falls0 = cs_falls;
        bus_write(4'h0, 32'h100);
        bus_read(4'h0, v); check("R3 zero-count busy", v, 32'h0);
        check("R3 zero-count cs_n", 32'(spi_cs_n), 32'd1);
        check("R3 zero-count no transaction", 32'(cs_falls - falls0), 32'd0);

        // R4 R5 sweep of counts
        for (int tx = 0; tx <= 5; tx++)
            for (int rx = 0; rx <= 5; rx++)
                if (tx + rx > 0)
                    run_cmd(tx, rx, {8'(tx * 17), 8'(rx * 51), 8'h6E, 8'(8'h10 + tx + rx)});

        // R2 counts readable after the sweep's last write (tx=5 rx=5)
        bus_read(4'h0, v); check("R2 ctrl counts readback", v, 32'h55);

        // R8 writes while busy are ignored
        bus_write(4'h4, 32'h1122_3344);
        falls0 = cs_falls;
        bus_write(4'h0, 32'h112);
        bus_write(4'h4, 32'hDEAD_BEEF);
        bus_write(4'h0, 32'h177);
        wait_idle();
        bus_read(4'h4, v); check("R8 opcode kept", v, 32'h1122_3344);
        bus_read(4'h0, v); check("R8 ctrl kept", v, 32'h12);
        check("R8 single transaction", 32'(cs_falls - falls0), 32'd1);

        // R9 signature read for every size code
        for (int s = 8'h13; s <= 8'h16; s++) begin
            sig = 8'(s);
            bus_write(4'h4, 32'h0000_00AB);
            bus_write(4'h0, 32'h114);
            wait_idle();
            bus_read(4'h8, v);
            check($sformatf("R9 signature %0h", s), v, 32'(s));
            check($sformatf("R9 size MiB for %0h", s), 32'(1 << (v[7:0] - 8'h13)), 32'(1 << (s - 8'h13)));
        end

        repeat (10) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule